// File: doc/BRIEF.md
# Keypad and Seven-Segment Display Port

This block is a small I/O peripheral that sits in the top 64 KiB of a 32-bit address space. A processor talks to it with ordinary byte loads and stores. Two byte registers drive the segments of a two-digit seven-segment display directly. A control byte selects which rows of a 4x4 hexadecimal keypad are driven and holds the enable for a keypad interrupt. A status byte reports the debounced row-and-column code of the pressed key.

The bus is single-cycle. Stores take effect at the clock edge where `bus_we` is high. Load data is combinational from the address while `bus_re` is high. Column inputs are asynchronous to the clock. They pass through a synchronizer and then a debounce state machine with four states. In `DB_IDLE` no key is reported. On a non-zero column sample it moves through `PRESS_START` to `DB_PRESS_WAIT`. There a change of sample either restarts the count (`PRESS_RESTART`) or, if the sample returns to zero, goes back to `DB_IDLE` (`PRESS_ABORT`). A full stable count moves it to `DB_HELD` (`PRESS_DONE`). In `DB_HELD` a differing sample moves it to `DB_RELEASE_WAIT` (`CHANGE_START`). In `DB_RELEASE_WAIT` three things can happen. The old pattern returning moves it back to `DB_HELD` (`CHANGE_CANCEL`). A new pattern restarts the count (`CHANGE_RESTART`). A full count commits the new pattern, which leads to `DB_IDLE` for zero (`RELEASE_DONE`) or to `DB_HELD` with a new press event (`REPRESS_DONE`).

A second two-state machine holds the interrupt. It moves from `IRQ_IDLE` to `IRQ_PEND` on a press event while enabled (`IRQ_RAISE`). It moves back to `IRQ_IDLE` when the key byte is read (`IRQ_ACK`). A press event and a read in the same cycle keep it pending.

Top module: `kpdio_periph`

## Requirements
- R1: Only addresses whose upper 16 bits are 0xFFFF are decoded; a write outside that window changes no register and a read outside it returns 0.
- R2: A byte write to 0xFFFF0010 loads the right-digit segment outputs; bit 0 drives segment a through bit 6 segment g, bit 7 the decimal point, all active high.
- R3: A byte write to 0xFFFF0011 loads the left-digit segment outputs with the same bit mapping as R2.
- R4: A byte write to 0xFFFF0012 loads the control byte: bits 3:0 drive keypad rows 0 to 3 active high, bit 7 enables the keypad interrupt, and bits 6:4 are stored.
- R5: Reads of 0xFFFF0010, 0xFFFF0011 and 0xFFFF0012 return the byte last written there.
- R6: A read of 0xFFFF0014 returns the debounced key code: selected rows one-hot in bits 3:0 and pressed columns one-hot in bits 7:4 (row 0, column 0 reads 0x11). It returns 0 when no key is pressed or no row is selected, so a key on an unselected row is not reported.
- R7: A column change is reported no earlier than DEB_CYCLES clock edges after it reaches the pins and no later than DEB_CYCLES+4 edges after. A pulse shorter than DEB_CYCLES is never reported.
- R8: After a release, the key code returns to 0 within DEB_CYCLES+4 edges.
- R9: The interrupt output rises only after a new press event while control bit 7 is 1; with bit 7 at 0 a press leaves it low.
- R10: Once high, the interrupt stays high until a read of 0xFFFF0014, which clears it unless a new enabled press arrives in the same cycle.
- R11: Writes to 0xFFFF0014 and to unmapped offsets in the window change nothing; reads of unmapped offsets return 0.
- R12: Reset clears both segment bytes and the control byte, so all segments are off, no row is driven and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address |
| bus_we | input | 1 | Byte write strobe |
| bus_re | input | 1 | Read enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_re is high |
| kp_row_o | output | 4 | Keypad row drive, active high |
| kp_col_i | input | 4 | Keypad column sense, active high, asynchronous |
| seg_right_o | output | 8 | Right digit segments a..g and point |
| seg_left_o | output | 8 | Left digit segments a..g and point |
| key_irq_o | output | 1 | Keypad interrupt, active high |

## Verification
The properties assume that the bus holds a known address whenever a strobe is high, and that a read strobe lasts one cycle per access. They do not constrain column timing. The debounce machine is meant to absorb arbitrary column changes, so the only timing claims made are about the reported code and the interrupt. The stimulus drives one access at a time on the falling clock edge. It produces column values from a modelled key matrix crossed with the driven rows, so columns only change when a modelled key or the row selection changes.

// File: rtl/kpdio_pkg.sv
package kpdio_pkg;

    localparam int unsigned KP_ROWS   = 4;
    localparam int unsigned KP_COLS   = 4;
    localparam int unsigned BUS_AW    = 32;
    localparam int unsigned BUS_DW    = 8;
    localparam int unsigned WIN_W     = 16;
    localparam int unsigned OFF_W     = BUS_AW - WIN_W;
    localparam int unsigned IEN_BIT   = 7;

    localparam logic [WIN_W-1:0] WIN_TAG   = 16'hFFFF;
    localparam logic [OFF_W-1:0] OFF_SEG_R = 16'h0010;
    localparam logic [OFF_W-1:0] OFF_SEG_L = 16'h0011;
    localparam logic [OFF_W-1:0] OFF_CTRL  = 16'h0012;
    localparam logic [OFF_W-1:0] OFF_KEY   = 16'h0014;

    typedef enum logic [1:0] {
        DB_IDLE,
        DB_PRESS_WAIT,
        DB_HELD,
        DB_RELEASE_WAIT
    } db_state_t;

    typedef enum logic {
        IRQ_IDLE,
        IRQ_PEND
    } irq_state_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SEG_R,
        SEL_SEG_L,
        SEL_CTRL,
        SEL_KEY
    } reg_sel_t;

endpackage

// File: rtl/kpdio_bus_regs.sv
module kpdio_bus_regs
    import kpdio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BUS_AW-1:0]   addr,
    input  logic                we,
    input  logic                re,
    input  logic [BUS_DW-1:0]   wdata,
    input  logic [BUS_DW-1:0]   key_code,
    output logic [BUS_DW-1:0]   rdata,
    output logic [BUS_DW-1:0]   seg_r_o,
    output logic [BUS_DW-1:0]   seg_l_o,
    output logic [KP_ROWS-1:0]  row_o,
    output logic                ien_o,
    output logic                key_rd_o
);

    logic [BUS_DW-1:0] seg_r_q, seg_l_q, ctrl_q;
    logic              in_win;
    reg_sel_t          sel;

    assign in_win = (addr[BUS_AW-1:OFF_W] == WIN_TAG);

    always_comb begin
        sel = SEL_NONE;
        if (in_win) begin
            unique case (addr[OFF_W-1:0])
                OFF_SEG_R: sel = SEL_SEG_R;
                OFF_SEG_L: sel = SEL_SEG_L;
                OFF_CTRL:  sel = SEL_CTRL;
                OFF_KEY:   sel = SEL_KEY;
                default:   sel = SEL_NONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_r_q <= '0;
            seg_l_q <= '0;
            ctrl_q  <= '0;
        end else if (we) begin
            if (sel == SEL_SEG_R) seg_r_q <= wdata;
            if (sel == SEL_SEG_L) seg_l_q <= wdata;
            if (sel == SEL_CTRL)  ctrl_q  <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (re) begin
            unique case (sel)
                SEL_SEG_R: rdata = seg_r_q;
                SEL_SEG_L: rdata = seg_l_q;
                SEL_CTRL:  rdata = ctrl_q;
                SEL_KEY:   rdata = key_code;
                default:   rdata = '0;
            endcase
        end
    end

    assign seg_r_o  = seg_r_q;
    assign seg_l_o  = seg_l_q;
    assign row_o    = ctrl_q[KP_ROWS-1:0];
    assign ien_o    = ctrl_q[IEN_BIT];
    assign key_rd_o = re && (sel == SEL_KEY);

endmodule

// File: rtl/kpdio_col_debounce.sv
module kpdio_col_debounce
    import kpdio_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DEB_CYCLES  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [KP_COLS-1:0] col_i,
    output logic [KP_COLS-1:0] cols_o,
    output logic               press_o
);

    localparam int unsigned CNT_W = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

    logic [KP_COLS-1:0] sync_q [SYNC_STAGES];
    logic [KP_COLS-1:0] samp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
        end else begin
            sync_q[0] <= col_i;
            for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
        end
    end

    assign samp = sync_q[SYNC_STAGES-1];

    db_state_t          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [KP_COLS-1:0] cand_q, cand_d;
    logic [KP_COLS-1:0] db_q, db_d;
    logic               press_q, press_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DB_IDLE;
            cnt_q   <= '0;
            cand_q  <= '0;
            db_q    <= '0;
            press_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            cand_q  <= cand_d;
            db_q    <= db_d;
            press_q <= press_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        cand_d  = cand_q;
        db_d    = db_q;
        press_d = 1'b0;
        unique case (state_q)
            DB_IDLE: begin
                if (samp != '0) begin
                    state_d = DB_PRESS_WAIT;
                    cand_d  = samp;
                    cnt_d   = '0;
                end
            end
            DB_PRESS_WAIT: begin
                if (samp != cand_q) begin
                    if (samp == '0) begin
                        state_d = DB_IDLE;
                    end else begin
                        cand_d = samp;
                        cnt_d  = '0;
                    end
                end else if (cnt_q == CNT_LAST) begin
                    state_d = DB_HELD;
                    db_d    = cand_q;
                    press_d = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            DB_HELD: begin
                if (samp != db_q) begin
                    state_d = DB_RELEASE_WAIT;
                    cand_d  = samp;
                    cnt_d   = '0;
                end
            end
            DB_RELEASE_WAIT: begin
                if (samp == db_q) begin
                    state_d = DB_HELD;
                end else if (samp != cand_q) begin
                    cand_d = samp;
                    cnt_d  = '0;
                end else if (cnt_q == CNT_LAST) begin
                    db_d = cand_q;
                    if (cand_q == '0) begin
                        state_d = DB_IDLE;
                    end else begin
                        state_d = DB_HELD;
                        press_d = 1'b1;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = DB_IDLE;
        endcase
    end

    assign cols_o  = db_q;
    assign press_o = press_q;

endmodule

// File: rtl/kpdio_irq_ctl.sv
module kpdio_irq_ctl
    import kpdio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic press_i,
    input  logic ien_i,
    input  logic ack_i,
    output logic irq_o
);

    irq_state_t state_q, state_d;
    logic       raise;

    assign raise = press_i && ien_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (raise)           state_d = IRQ_PEND;
            IRQ_PEND: if (ack_i && !raise) state_d = IRQ_IDLE;
            default:                       state_d = IRQ_IDLE;
        endcase
    end

    assign irq_o = (state_q == IRQ_PEND);

endmodule

// File: rtl/kpdio_periph.sv
module kpdio_periph
    import kpdio_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DEB_CYCLES  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] bus_addr,
    input  logic        bus_we,
    input  logic        bus_re,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic [3:0]  kp_row_o,
    input  logic [3:0]  kp_col_i,
    output logic [7:0]  seg_right_o,
    output logic [7:0]  seg_left_o,
    output logic        key_irq_o
);

    logic [KP_ROWS-1:0] row_w;
    logic [KP_COLS-1:0] cols_w;
    logic [BUS_DW-1:0]  key_code_w;
    logic               ien_w, key_rd_w, press_w, row_any;

    kpdio_bus_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .we       (bus_we),
        .re       (bus_re),
        .wdata    (bus_wdata),
        .key_code (key_code_w),
        .rdata    (bus_rdata),
        .seg_r_o  (seg_right_o),
        .seg_l_o  (seg_left_o),
        .row_o    (row_w),
        .ien_o    (ien_w),
        .key_rd_o (key_rd_w)
    );

    kpdio_col_debounce #(
        .SYNC_STAGES (SYNC_STAGES),
        .DEB_CYCLES  (DEB_CYCLES)
    ) u_deb (
        .clk     (clk),
        .rst_n   (rst_n),
        .col_i   (kp_col_i),
        .cols_o  (cols_w),
        .press_o (press_w)
    );

    assign row_any    = (row_w != '0);
    assign key_code_w = (row_any && cols_w != '0) ? {cols_w, row_w} : '0;

    kpdio_irq_ctl u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .press_i (press_w && row_any),
        .ien_i   (ien_w),
        .ack_i   (key_rd_w),
        .irq_o   (key_irq_o)
    );

    assign kp_row_o = row_w;

endmodule

// File: rtl/kpdio_periph_chk.sv
module kpdio_periph_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] bus_addr,
    input logic        bus_we,
    input logic        bus_re,
    input logic [7:0]  bus_rdata,
    input logic [3:0]  kp_row_o,
    input logic [7:0]  seg_right_o,
    input logic [7:0]  seg_left_o,
    input logic        key_irq_o,
    input logic        ien,
    input logic        key_rd
);

    logic in_win, mapped;
    assign in_win = (bus_addr[31:16] == 16'hFFFF);
    assign mapped = (bus_addr[15:0] == 16'h0010) || (bus_addr[15:0] == 16'h0011) ||
                    (bus_addr[15:0] == 16'h0012) || (bus_addr[15:0] == 16'h0014);

    assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_irq_o) |-> $past(ien));

    assert_irq_clear_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(key_irq_o) |-> $past(key_rd));

    assert_seg_right_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == 32'hFFFF0010) |=> $stable(seg_right_o));

    assert_seg_left_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == 32'hFFFF0011) |=> $stable(seg_left_o));

    assert_row_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == 32'hFFFF0012) |=> $stable(kp_row_o));

    assert_outside_read_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !in_win) |-> (bus_rdata == 8'h00));

    assert_unmapped_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && in_win && !mapped) |-> (bus_rdata == 8'h00));

endmodule

bind kpdio_periph kpdio_periph_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_re      (bus_re),
    .bus_rdata   (bus_rdata),
    .kp_row_o    (kp_row_o),
    .seg_right_o (seg_right_o),
    .seg_left_o  (seg_left_o),
    .key_irq_o   (key_irq_o),
    .ien         (ien_w),
    .key_rd      (key_rd_w)
);

// File: tb/kpdio_periph_tb_top.sv
`timescale 1ns/1ps
module kpdio_periph_tb_top;

    localparam int DEB = 16;
    localparam int NVEC = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [3:0]  kp_row_o;
    logic [3:0]  kp_col_i;
    logic [7:0]  seg_right_o, seg_left_o;
    logic        key_irq_o;
    logic [15:0] key_down = '0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    kpdio_periph #(.DEB_CYCLES(DEB)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .kp_row_o(kp_row_o), .kp_col_i(kp_col_i), .seg_right_o(seg_right_o),
        .seg_left_o(seg_left_o), .key_irq_o(key_irq_o)
    );

    // key (r,c) is key_down[r*4+c]; a column reads 1 when a pressed key on a driven row connects it
    always_comb begin
        for (int c = 0; c < 4; c++)
            kp_col_i[c] = |(kp_row_o & {key_down[12+c], key_down[8+c], key_down[4+c], key_down[c]});
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            failures = failures + 1;
            $display("FAIL watchdog: got=%0d cycles exp=<50000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    // {is_read, in_window, offset, data (write value or expected read)}
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 8'h10, 8'h3F},   // R2
        {1'b0, 1'b1, 8'h11, 8'h06},   // R3
        {1'b0, 1'b1, 8'h12, 8'h71},   // R4
        {1'b1, 1'b1, 8'h10, 8'h3F},   // R5
        {1'b1, 1'b1, 8'h11, 8'h06},   // R5
        {1'b1, 1'b1, 8'h12, 8'h71},   // R5 R4
        {1'b0, 1'b1, 8'h14, 8'hAA},   // R11
        {1'b1, 1'b1, 8'h14, 8'h00},   // R6 R11
        {1'b0, 1'b1, 8'h13, 8'h55},   // R11
        {1'b1, 1'b1, 8'h13, 8'h00},   // R11
        {1'b0, 1'b0, 8'h10, 8'hFF},   // R1
        {1'b1, 1'b1, 8'h10, 8'h3F},   // R1
        {1'b1, 1'b0, 8'h10, 8'h00},   // R1
        {1'b0, 1'b1, 8'h1F, 8'h12},   // R11
        {1'b1, 1'b1, 8'h1F, 8'h00},   // R11
        {1'b0, 1'b1, 8'h11, 8'h80},   // R3
        {1'b1, 1'b1, 8'h11, 8'h80}    // R5
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks = checks + 1;
        if (got !== exp) begin
            failures = failures + 1;
            $display("FAIL %s: got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] mk_addr(input logic win, input logic [7:0] off);
        return {(win ? 16'hFFFF : 16'h1000), 8'h00, off};
    endfunction

    task automatic bus_wr(input logic win, input logic [7:0] off, input logic [7:0] d);
        @(negedge clk);
        bus_addr = mk_addr(win, off);
        bus_wdata = d;
        bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic win, input logic [7:0] off, output logic [7:0] d);
        @(negedge clk);
        bus_addr = mk_addr(win, off);
        bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    initial begin
        logic [7:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12 seg_right reset", seg_right_o, 8'h00);
        chk("R12 seg_left reset", seg_left_o, 8'h00);
        chk("R12 rows reset", kp_row_o, 4'h0);
        chk("R12 irq reset", key_irq_o, 1'b0);
        rst_n = 1'b1;
        bus_rd(1'b1, 8'h12, rd);
        chk("R12 ctrl readback after reset", rd, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][17]) begin
                bus_rd(VEC[i][16], VEC[i][15:8], rd);
                chk($sformatf("R5/R1/R11 vector %0d", i), rd, VEC[i][7:0]);
            end else begin
                bus_wr(VEC[i][16], VEC[i][15:8], VEC[i][7:0]);
            end
        end
        chk("R2 seg_right pins", seg_right_o, 8'h3F);
        chk("R3 seg_left pins", seg_left_o, 8'h80);
        chk("R4 row pins", kp_row_o, 4'h1);

        // debounce window, interrupt disabled
        @(negedge clk);
        key_down[0] = 1'b1;
        repeat (DEB) @(posedge clk);
        bus_rd(1'b1, 8'h14, rd);
        chk("R7 not reported early", rd, 8'h00);
        repeat (4) @(posedge clk);
        bus_rd(1'b1, 8'h14, rd);
        chk("R6 R7 code row0 col0", rd, 8'h11);
        chk("R9 no irq when disabled", key_irq_o, 1'b0);
        @(negedge clk);
        key_down[0] = 1'b0;
        repeat (DEB + 4) @(posedge clk);
        bus_rd(1'b1, 8'h14, rd);
        chk("R8 release clears code", rd, 8'h00);

        // interrupt enabled
        bus_wr(1'b1, 8'h12, 8'h81);
        @(negedge clk);
        key_down[2] = 1'b1;
        repeat (DEB + 8) @(posedge clk);
        @(negedge clk);
        chk("R9 irq on enabled press", key_irq_o, 1'b1);
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk("R10 irq held until read", key_irq_o, 1'b1);
        bus_rd(1'b1, 8'h14, rd);
        chk("R6 code row0 col2", rd, 8'h41);
        chk("R10 irq cleared by read", key_irq_o, 1'b0);
        @(negedge clk);
        key_down[2] = 1'b0;
        repeat (DEB + 8) @(posedge clk);

        // row selection
        bus_wr(1'b1, 8'h12, 8'h82);
        @(negedge clk);
        key_down[1] = 1'b1;
        repeat (DEB + 8) @(posedge clk);
        bus_rd(1'b1, 8'h14, rd);
        chk("R6 unselected row not seen", rd, 8'h00);
        chk("R9 no irq for unselected row", key_irq_o, 1'b0);
        @(negedge clk);
        key_down[7] = 1'b1;
        repeat (DEB + 8) @(posedge clk);
        @(negedge clk);
        chk("R9 irq row1 press", key_irq_o, 1'b1);
        bus_rd(1'b1, 8'h14, rd);
        chk("R6 code row1 col3", rd, 8'h82);
        chk("R10 cleared again", key_irq_o, 1'b0);
        @(negedge clk);
        key_down = '0;
        repeat (DEB + 8) @(posedge clk);

        // short pulse
        @(negedge clk);
        key_down[4] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        key_down[4] = 1'b0;
        repeat (2 * DEB) @(posedge clk);
        bus_rd(1'b1, 8'h14, rd);
        chk("R7 short pulse ignored", rd, 8'h00);
        chk("R7 short pulse no irq", key_irq_o, 1'b0);

        // reset in the middle of a run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R12 seg_right cleared", seg_right_o, 8'h00);
        chk("R12 seg_left cleared", seg_left_o, 8'h00);
        chk("R12 rows deselected", kp_row_o, 4'h0);
        chk("R12 irq low", key_irq_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        bus_rd(1'b1, 8'h12, rd);
        chk("R12 ctrl cleared", rd, 8'h00);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule